// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog peripheral with a small word-addressed register interface. It has two control/status registers and one read-only timebase register. An interval counter measures windows of 2^N clock cycles, where N is set by a parameter. When a window runs out for the first time, the block sets a state flag, and that flag drives a level interrupt. If a second window runs out while the flag is still set, the block raises a reset request for one clock and sets a sticky reset-status flag. The worst-case time from the last service to the reset request is therefore two windows.

Software services the timer by writing ones to the flag bits, which clears the flags and restarts the window. The timer runs while either of its two enable bits is set. The two bits sit in different registers, so one stray write cannot stop the timer. An enable-once parameter removes the ability to stop the timer at all once it has been started. A free-running timebase counter, readable at any time, lets software confirm that the clock is alive.

Top module: `dual_stage_wdt`

## Requirements
- R1: Register selection uses `bus_addr[3:2]`:
  - 0 selects control register A.
  - 1 selects control register B.
  - 2 selects the timebase.
  - 3 reads as all zeros and writes to it have no effect.
  - `bus_rdata` is combinational from the address while `bus_sel` is high.
- R2: Control register A holds enable bit 1 at bit 1, the state flag at bit 2 and the reset-status flag at bit 3. Control register B holds enable bit 2 at bit 0. Every other bit of either register ignores writes and reads as 0.
- R3: The interval counter advances while enable bit 1 or enable bit 2 is set. It is held at zero only when both are 0. While both are 0, the flags never change by expiry.
- R4: The state flag sets at the clock edge 2^N cycles after the edge that enabled the timer, and `irq` equals the state flag.
- R5: When a window expires while the state flag is set, `sys_rst_req` is high for exactly one clock. The same edge sets the reset-status flag, which then holds until software clears it. This happens 2·2^N cycles after enabling.
- R6: While the reset-status flag stays set, further expiries produce no additional reset pulse.
- R7: Writing 1 to bit 2 of register A clears the state flag, and writing 1 to bit 3 clears the reset-status flag. Either write restarts the window from zero. Writing 0 to those bits leaves the flags unchanged.
- R8: A transition from disabled to enabled starts the window from zero, so partial counts from before a stop are discarded.
- R9: The timebase is a free-running counter from reset that increases by one every clock. Two reads one clock apart differ by one.
- R10: With ENABLE_ONCE set, a write cannot clear an enable bit once the timer is running. With ENABLE_ONCE clear, writing 0 to both enable bits stops the timer.
- R11: After reset, both control registers read 0 and `irq` and `sys_rst_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| irq | output | 1 | Level interrupt, high while the state flag is set |
| sys_rst_req | output | 1 | One-clock reset request on the second expiry |

## Verification
The bench counts edges from the enabling write and samples the interrupt one cycle before and exactly at the expected edge. A counter that was off by one, or that did not restart on service or re-enable, would move that edge. It also checks that a single-enable configuration still counts, that the reset pulse lasts one clock, and that it never repeats while the status flag is held. A design that gated the timer on both enable bits, or that re-fired the reset on every later window, would fail these checks. Reserved bits, the unused word and a zero write to the flag bits are all checked for no effect. The enable-once instance is checked for a stop attempt that must not take hold.

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt #(
  parameter int INTERVAL_LOG2 = 16,
  parameter bit ENABLE_ONCE   = 1'b0,
  parameter int TB_WIDTH      = 32,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sys_rst_req
);

  localparam logic [INTERVAL_LOG2-1:0] CNT_LAST = '1;
  localparam int BIT_EN1   = 1;
  localparam int BIT_STATE = 2;
  localparam int BIT_RSTAT = 3;
  localparam int BIT_EN2   = 0;

  logic [INTERVAL_LOG2-1:0] cnt_q;
  logic [TB_WIDTH-1:0]      tb_q;
  logic en1_q, en2_q, state_q, rstat_q, pulse_q;

  wire wr_a    = bus_sel && bus_wr && (bus_addr[3:2] == 2'd0);
  wire wr_b    = bus_sel && bus_wr && (bus_addr[3:2] == 2'd1);
  wire kick    = wr_a && (bus_wdata[BIT_STATE] || bus_wdata[BIT_RSTAT]);
  wire running = en1_q || en2_q;
  wire locked  = ENABLE_ONCE && running;
  wire expire  = running && !kick && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tb_q    <= '0;
      en1_q   <= 1'b0;
      en2_q   <= 1'b0;
      state_q <= 1'b0;
      rstat_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      tb_q <= tb_q + 1'b1;

      if (!running || kick) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;

      if (wr_a) en1_q <= bus_wdata[BIT_EN1] || (locked && en1_q);
      if (wr_b) en2_q <= bus_wdata[BIT_EN2] || (locked && en2_q);

      if (wr_a && bus_wdata[BIT_STATE]) state_q <= 1'b0;
      else if (expire)                  state_q <= 1'b1;

      if (wr_a && bus_wdata[BIT_RSTAT]) rstat_q <= 1'b0;
      else if (expire && state_q)       rstat_q <= 1'b1;

      pulse_q <= expire && state_q && !rstat_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (bus_addr[3:2])
        2'd0: begin
          bus_rdata[BIT_EN1]   = en1_q;
          bus_rdata[BIT_STATE] = state_q;
          bus_rdata[BIT_RSTAT] = rstat_q;
        end
        2'd1:    bus_rdata[BIT_EN2] = en2_q;
        2'd2:    bus_rdata[TB_WIDTH-1:0] = tb_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq         = state_q;
  assign sys_rst_req = pulse_q;

  // R5: the reset request is a single-clock pulse
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  // R5: a reset request only follows a cycle in which the state flag was set
  a_r5_pulse_after_state: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(state_q));

  // R5: reset status holds until a clearing write
  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rstat_q && !(wr_a && bus_wdata[BIT_RSTAT])) |=> rstat_q);

  // R6: no fresh pulse while reset status is already set
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    rstat_q |=> !sys_rst_req);

  // R3: with both enables clear and no write, the flags do not move
  a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_a) |=> ($stable(state_q) && $stable(rstat_q)));

  // R4: the interrupt only rises while the timer runs
  a_r4_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(running));

  // R9: the timebase never stands still
  a_r9_tb_moves: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tb_q != $past(tb_q)));

  // R10: under enable-once, a running timer stays running
  a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ENABLE_ONCE && running) |=> running);

endmodule

// File: tb/test_dual_stage_wdt.sv
`timescale 1ns/1ps
module test_dual_stage_wdt;
  localparam int N = 4;
  localparam int WIN = 1 << N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic irq_a, irq_b, rr_a, rr_b;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_stage_wdt #(.INTERVAL_LOG2(N), .ENABLE_ONCE(1'b0)) i_dual_stage_wdt (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_a), .irq(irq_a), .sys_rst_req(rr_a));

  dual_stage_wdt #(.INTERVAL_LOG2(N), .ENABLE_ONCE(1'b1)) i_dual_stage_wdt_once (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_b), .irq(irq_b), .sys_rst_req(rr_b));

  // {write, addr[3:0], wdata[31:0], expected readback[31:0]}
  localparam logic [68:0] VEC [8] = '{
    {1'b1, 4'h0, 32'hFFFF_FFFF, 32'h0000_0002},
    {1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 4'hC, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b1, 4'h4, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 4'h0, 32'hFFFF_FFF0, 32'h0000_0000},
    {1'b1, 4'h4, 32'hFFFF_FFFE, 32'h0000_0000},
    {1'b1, 4'h0, 32'h0000_0002, 32'h0000_0002},
    {1'b1, 4'h0, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input bit b, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_a = !b; sel_b = b; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b0; wr = 1'b0;
  endtask

  task automatic peek(input bit b, input logic [3:0] a, output logic [31:0] v);
    sel_a = !b; sel_b = b; wr = 1'b0; addr = a;
    #1;
    v = b ? rd_b : rd_a;
    sel_a = 1'b0; sel_b = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    peek(0, 4'h0, v); check("R11 csrA", v, 0);
    peek(0, 4'h4, v); check("R11 csrB", v, 0);
    check("R11 irq", {31'b0, irq_a}, 0);
    check("R11 rst", {31'b0, rr_a}, 0);

    // R1 R2 R10(stop allowed) table walk
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][68]) wr_reg(0, VEC[i][67:64], VEC[i][63:32]);
      peek(0, VEC[i][67:64], v);
      check($sformatf("R1/R2 vec%0d", i), v, VEC[i][31:0]);
    end

    // R3 single enable counts; R4 first expiry; R5 second expiry
    wr_reg(0, 4'h4, 32'h1);
    repeat (WIN-1) @(negedge clk);
    check("R4 irq before window", {31'b0, irq_a}, 0);
    @(negedge clk);
    check("R4 irq at window (R3 en2 only)", {31'b0, irq_a}, 1);
    peek(0, 4'h0, v); check("R4 state flag", v, 32'h4);
    repeat (WIN-1) @(negedge clk);
    check("R5 no pulse early", {31'b0, rr_a}, 0);
    @(negedge clk);
    check("R5 pulse", {31'b0, rr_a}, 1);
    peek(0, 4'h0, v); check("R5 status set", v, 32'hC);
    @(negedge clk);
    check("R5 pulse one clock", {31'b0, rr_a}, 0);
    pulses = 0;
    for (int k = 0; k < 3*WIN; k++) begin
      @(negedge clk);
      if (rr_a) pulses++;
    end
    check("R6 no repeat pulse", pulses, 0);
    peek(0, 4'h0, v); check("R5 status sticky", v, 32'hC);

    // R7 keepalive
    wr_reg(0, 4'h0, 32'h4);
    peek(0, 4'h0, v); check("R7 clear state only", v, 32'h8);
    wr_reg(0, 4'h0, 32'h8);
    peek(0, 4'h0, v); check("R7 clear status", v, 32'h0);
    repeat (WIN-1) @(negedge clk);
    check("R7 restart before", {31'b0, irq_a}, 0);
    @(negedge clk);
    check("R7 restart at window", {31'b0, irq_a}, 1);
    wr_reg(0, 4'h0, 32'h0);
    peek(0, 4'h0, v); check("R7 zero write keeps flag", v, 32'h4);
    wr_reg(0, 4'h0, 32'h4);
    check("R7 irq cleared", {31'b0, irq_a}, 0);

    // R3 both enables clear stops the timer
    wr_reg(0, 4'h4, 32'h0);
    pulses = 0;
    for (int k = 0; k < 3*WIN; k++) begin
      @(negedge clk);
      if (irq_a || rr_a) pulses++;
    end
    check("R3 stopped no events", pulses, 0);
    peek(0, 4'h0, v); check("R3 stopped csrA", v, 0);

    // R8 restart on re-enable
    wr_reg(0, 4'h0, 32'h2);
    repeat (WIN/2) @(negedge clk);
    wr_reg(0, 4'h0, 32'h0);
    repeat (3) @(negedge clk);
    wr_reg(0, 4'h0, 32'h2);
    repeat (WIN-1) @(negedge clk);
    check("R8 irq before window", {31'b0, irq_a}, 0);
    @(negedge clk);
    check("R8 irq at window", {31'b0, irq_a}, 1);
    wr_reg(0, 4'h0, 32'h4);

    // R9 timebase
    peek(0, 4'h8, v);
    @(negedge clk);
    peek(0, 4'h8, v2);
    check("R9 timebase step", v2, v + 32'd1);

    // R10 enable-once instance refuses to stop
    wr_reg(1, 4'h0, 32'h2);
    wr_reg(1, 4'h4, 32'h1);
    wr_reg(1, 4'h4, 32'h0);
    wr_reg(1, 4'h0, 32'h0);
    peek(1, 4'h0, v); check("R10 en1 held", v & 32'h2, 32'h2);
    peek(1, 4'h4, v); check("R10 en2 held", v, 32'h1);

    finish_run();
  end
endmodule